// File: doc/BRIEF.md
# Input Change Capture Unit

The block watches a group of digital event inputs (eight by default) and keeps two banks of per-input latches. The **capture bank** ("new") records the first level change seen on each input. It then freezes that input's bit until the host reads the bank. The **history bank** ("old") holds the level each input had before the change that was last reported. Any reported change sets a change flag in the status byte and pulls an active-low change-information output low. When the mode controller allows reset generation, the same change also raises a one-cycle wake request.

The host reaches the block through three single-cycle read strobes: status, history and capture. The three bytes are always visible on their output ports, and a strobe only triggers the side effect that belongs to that read. None of these interfaces carries a data stream, so the block has no valid/ready handshake and applies no back-pressure. A strobe is taken on the clock edge where it is high, and it must be held for exactly one cycle per read.

The upper four inputs can be masked through a four-bit field. A masked input never reports a change. Instead, both of its bank bits follow its synchronized level.

Top module: `chg_capture`

## Requirements
- R1: Once an input's capture bit has taken a new level, it keeps that level, even if the input changes again, until a capture-bank read strobe (`rd_new`) arrives.
- R2: A capture-bank read copies every unmasked capture bit into its history bit on that edge and re-arms the latch. If the synchronized input already differs from the capture bit, it is captured on the following edge. Each capture also loads the history bit with the capture bit's level from before the change.
- R3: A history-bank read strobe (`rd_old`) changes no latch, no status bit and no output.
- R4: Bit j of `mask_hi` masks input j+4. A masked input never sets the status flag, never pulls `chg_n` low and never raises `wake_req`. Inputs 0 to 3 cannot be masked.
- R5: While an input is masked, its capture and history bits both equal its synchronized level, updated every clock.
- R6: A capture on any unmasked input sets status bit 7 (`status_byte` = 8'h80; bits 6..0 are always 0) and drives `chg_n` low. The flag holds until it is cleared.
- R7: A status read strobe clears bit 7 and returns `chg_n` high. If a capture happens on the same edge, the capture wins and the flag stays set.
- R8: During and just after reset (`rst_n` low), `status_byte` is 0, `chg_n` is 1 and `wake_req` is 0. Both banks equal the synchronized input levels present during reset, and every latch is armed.
- R9: `wake_req` is high for exactly the one cycle after a capturing edge, and only if `rst_gen_en` was high on that edge.
- R10: An input change that is set up before rising edge 1 shows on the banks, `status_byte`, `chg_n` and `wake_req` after rising edge 3. Edges 1 and 2 pass it through two synchronizer stages, and edge 3 captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous device reset, active low |
| evt_in | input | 8 | Asynchronous event inputs |
| mask_hi | input | 4 | Mask for inputs 4..7 (1 = masked) |
| rst_gen_en | input | 1 | Reset-generation enable from the mode controller |
| rd_status | input | 1 | Status-byte read strobe |
| rd_old | input | 1 | History-bank read strobe |
| rd_new | input | 1 | Capture-bank read strobe |
| status_byte | output | 8 | Status byte; bit 7 is the change flag |
| old_byte | output | 8 | History bank |
| new_byte | output | 8 | Capture bank |
| chg_n | output | 1 | Change information, active low |
| wake_req | output | 1 | One-cycle wake / reset-pulse request |

## Verification
An input edge is due at the ports after three rising clock edges, and a read strobe's effect is due after the one edge that consumes it. A capture that a read has deferred lands one edge after that read. The bench drives stimulus on falling edges and counts falling edges to sample at those exact points. It also confirms that nothing moves in the cycles just before them, for example after two edges for the latency case. A behavioural model advanced on every rising edge is compared with all five outputs on every falling edge, and this catches results that arrive early, late or spuriously.

// File: rtl/chg_capture_pkg.sv
package chg_capture_pkg;

  localparam int STATUS_W  = 8;
  localparam int CHG_BIT   = 7;

  typedef struct packed {
    logic cap_q;
    logic hist_q;
    logic frozen;
  } lane_state_t;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) stg[g] <= stg[g-1];
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/chg_lane.sv
module chg_lane
  import chg_capture_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic masked,
  input  logic rd_new,
  output logic cap_bit,
  output logic hist_bit,
  output logic capture
);

  lane_state_t st;

  assign capture  = rst_n && !masked && !st.frozen && !rd_new && (s != st.cap_q);
  assign cap_bit  = st.cap_q;
  assign hist_bit = st.hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.cap_q  <= s;
      st.hist_q <= s;
      st.frozen <= 1'b0;
    end else if (masked) begin
      st.cap_q  <= s;
      st.hist_q <= s;
      st.frozen <= 1'b0;
    end else if (rd_new) begin
      st.hist_q <= st.cap_q;
      st.frozen <= 1'b0;
    end else if (capture) begin
      st.hist_q <= st.cap_q;
      st.cap_q  <= s;
      st.frozen <= 1'b1;
    end
  end

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st.frozen && !masked && !rd_new |=> cap_bit == $past(cap_bit)); // R1

  AST_READ_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    !masked && rd_new |=> hist_bit == $past(cap_bit)); // R2

  AST_MASK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> (cap_bit == $past(s)) && (hist_bit == $past(s))); // R5

endmodule

// File: rtl/chg_status.sv
module chg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic any_cap,
  input  logic rd_status,
  input  logic rst_gen_en,
  output logic chg_flag,
  output logic wake_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_flag <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      if (any_cap)        chg_flag <= 1'b1;
      else if (rd_status) chg_flag <= 1'b0;
      wake_req <= any_cap && rst_gen_en;
    end
  end

  AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_cap |=> chg_flag); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cap && !rd_status |=> $stable(chg_flag)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !any_cap |=> !chg_flag); // R7

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_gen_en |=> !wake_req); // R9

endmodule

// File: rtl/chg_capture.sv
module chg_capture
  import chg_capture_pkg::*;
#(
  parameter int NUM_IN      = 8,
  parameter int MASK_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IN-1:0]   evt_in,
  input  logic [MASK_W-1:0]   mask_hi,
  input  logic                rst_gen_en,
  input  logic                rd_status,
  input  logic                rd_old,
  input  logic                rd_new,
  output logic [STATUS_W-1:0] status_byte,
  output logic [NUM_IN-1:0]   old_byte,
  output logic [NUM_IN-1:0]   new_byte,
  output logic                chg_n,
  output logic                wake_req
);

  localparam int MASK_LO = NUM_IN - MASK_W;

  logic [NUM_IN-1:0] s_vec;
  logic [NUM_IN-1:0] mask_vec;
  logic [NUM_IN-1:0] cap_vec;
  logic              any_cap;
  logic              chg_flag;

  chg_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (evt_in),
    .q   (s_vec)
  );

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
      if (i >= MASK_LO) begin : g_mskbl
        assign mask_vec[i] = mask_hi[i-MASK_LO];
      end else begin : g_fixed
        assign mask_vec[i] = 1'b0;
      end

      chg_lane u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .s        (s_vec[i]),
        .masked   (mask_vec[i]),
        .rd_new   (rd_new),
        .cap_bit  (new_byte[i]),
        .hist_bit (old_byte[i]),
        .capture  (cap_vec[i])
      );
    end
  endgenerate

  assign any_cap = |cap_vec;

  chg_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_cap    (any_cap),
    .rd_status  (rd_status),
    .rst_gen_en (rst_gen_en),
    .chg_flag   (chg_flag),
    .wake_req   (wake_req)
  );

  always_comb begin
    status_byte          = '0;
    status_byte[CHG_BIT] = chg_flag;
  end

  assign chg_n = !chg_flag;

  AST_OLD_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_old && !rd_new && !any_cap && (mask_hi == '0) |=> old_byte == $past(old_byte)); // R3

  AST_CHG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_n) |-> $past(any_cap)); // R6

endmodule

// File: tb/chg_capture_test.sv
module chg_capture_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = 8'h00;
  logic [3:0] mask_hi = 4'h0;
  logic       rst_gen_en = 1'b1;
  logic       rd_status = 1'b0;
  logic       rd_old = 1'b0;
  logic       rd_new = 1'b0;
  logic [7:0] status_byte, old_byte, new_byte;
  logic       chg_n, wake_req;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chg_capture uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mask_hi(mask_hi),
    .rst_gen_en(rst_gen_en), .rd_status(rd_status), .rd_old(rd_old),
    .rd_new(rd_new), .status_byte(status_byte), .old_byte(old_byte),
    .new_byte(new_byte), .chg_n(chg_n), .wake_req(wake_req)
  );

  // behavioural reference: a two-deep delay line for the inputs, then per-input rules
  logic [7:0] hist_q[$];
  logic [7:0] m_new = 8'h00, m_old = 8'h00, m_frz = 8'h00;
  logic       m_flag = 1'b0, m_wake = 1'b0;

  always @(posedge clk) begin
    logic [7:0] s;
    bit any;
    s = (hist_q.size() == 2) ? hist_q[0] : 8'h00;
    any = 0;
    if (!rst_n) begin
      m_new = s; m_old = s; m_frz = 8'h00; m_flag = 0; m_wake = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit mk;
        mk = (i >= 4) ? mask_hi[i % 4] : 1'b0;
        if (mk) begin
          m_new[i] = s[i]; m_old[i] = s[i]; m_frz[i] = 0;
        end else if (rd_new) begin
          m_old[i] = m_new[i]; m_frz[i] = 0;
        end else if (!m_frz[i] && s[i] != m_new[i]) begin
          m_old[i] = m_new[i]; m_new[i] = s[i]; m_frz[i] = 1; any = 1;
        end
      end
      if (any) m_flag = 1;
      else if (rd_status) m_flag = 0;
      m_wake = any && rst_gen_en;
    end
    hist_q.push_back(evt_in);
    if (hist_q.size() > 2) void'(hist_q.pop_front());
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      check("R1/R2 model new_byte", new_byte, m_new);
      check("R2/R3 model old_byte", old_byte, m_old);
      check("R6/R7 model status_byte", status_byte, {m_flag, 7'b0});
      check("R6 model chg_n", {7'b0, chg_n}, {7'b0, !m_flag});
      check("R9 model wake_req", {7'b0, wake_req}, {7'b0, m_wake});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    if (which == 0) rd_status = 1'b1;
    else if (which == 1) rd_old = 1'b1;
    else rd_new = 1'b1;
    @(negedge clk);
    rd_status = 1'b0; rd_old = 1'b0; rd_new = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    evt_in = 8'hA5;
    cyc(5);
    // R8: reset state
    check("R8 status in reset", status_byte, 8'h00);
    check("R8 chg_n in reset", {7'b0, chg_n}, 8'h01);
    check("R8 new bank = inputs", new_byte, 8'hA5);
    check("R8 old bank = inputs", old_byte, 8'hA5);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cyc(2);
    check("R8 wake after reset", {7'b0, wake_req}, 8'h00);

    // R10: latency of a change on input 0
    evt_in = 8'hA4;
    cyc(1);
    check("R10 edge1 no change", status_byte, 8'h00);
    cyc(1);
    check("R10 edge2 no change", new_byte, 8'hA5);
    cyc(1);
    check("R10 edge3 new", new_byte, 8'hA4);
    check("R10 edge3 old", old_byte, 8'hA5);
    check("R6 chg_n low", {7'b0, chg_n}, 8'h00);
    check("R9 wake pulse", {7'b0, wake_req}, 8'h01);
    cyc(1);
    check("R9 wake one cycle", {7'b0, wake_req}, 8'h00);

    // R1: second change held off
    evt_in = 8'hA5;
    cyc(5);
    check("R1 new frozen", new_byte, 8'hA4);

    // R3: history read inert
    strobe(1);
    check("R3 old unchanged", old_byte, 8'hA5);
    check("R3 new unchanged", new_byte, 8'hA4);
    check("R3 status unchanged", status_byte, 8'h80);

    // R7: status read clears
    strobe(0);
    check("R7 status cleared", status_byte, 8'h00);
    check("R7 chg_n released", {7'b0, chg_n}, 8'h01);

    // R2: capture read moves new to old then recaptures the pending level
    strobe(2);
    check("R2 old <= new", old_byte, 8'hA4);
    check("R2 new before rearm capture", new_byte, 8'hA4);
    cyc(1);
    check("R2 rearmed capture", new_byte, 8'hA5);
    check("R2 old keeps pre level", old_byte, 8'hA4);
    check("R2 flag set", status_byte, 8'h80);
    strobe(0);

    // R4/R5: masked input 4 tracks live, no report
    mask_hi = 4'b0001;
    evt_in = 8'hB5;
    cyc(4);
    check("R4 masked no status", status_byte, 8'h00);
    check("R4 masked no wake", {7'b0, wake_req}, 8'h00);
    check("R5 masked new tracks", new_byte, 8'hB5);
    check("R5 masked old tracks", old_byte, 8'hB4);

    // R9: no wake while reset generation disabled
    mask_hi = 4'b0000;
    rst_gen_en = 1'b0;
    evt_in = 8'hB7;
    cyc(3);
    check("R9 flag without enable", status_byte, 8'h80);
    check("R9 wake gated", {7'b0, wake_req}, 8'h00);
    check("R2 new bit1", new_byte, 8'hB7);
    strobe(0);
    strobe(2);

    // R4: input 3 cannot be masked
    mask_hi = 4'hF;
    rst_gen_en = 1'b1;
    evt_in = 8'hBF;
    cyc(3);
    check("R4 input3 unmaskable", status_byte, 8'h80);
    check("R4 input3 wake", {7'b0, wake_req}, 8'h01);
    strobe(0);
    evt_in = 8'h3F;
    cyc(4);
    check("R4 input7 masked", status_byte, 8'h00);
    check("R5 input7 live", new_byte, 8'h3F);

    // R7: capture wins over simultaneous status read
    evt_in = 8'h3B;
    cyc(2);
    strobe(0);
    check("R7 set wins", status_byte, 8'h80);
    cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule